// File: doc/BRIEF.md
# Eight-Bit General-Purpose I/O Port with Reset-Class Retention

This block is one 8-bit general-purpose I/O port. The bus side reaches three registers through a 2-bit address: an output latch, a direction register and a read-only pin view. The pin side drives an output value and an output enable for each bit, and it samples the input levels through a two-stage synchronizer.

A small mode state machine sorts the control inputs into four states. `MODE_RUN` is normal operation. `MODE_MANUAL_RST` holds a manual reset. `MODE_SW_STBY` is software standby. `MODE_HW_STBY` is hardware standby. The next state depends only on the inputs, with priority hardware standby, then manual reset, then software standby, then run. So every state can move to every other state on any clock, in one step.

Each state treats the register contents in its own way:
- The asynchronous power-on reset clears everything.
- Hardware standby clears the output latch and the direction register on every clock while it is held.
- A manual reset keeps the register contents and blocks writes.
- Software standby keeps the register contents, blocks writes and freezes the synchronizer, so the pin view holds still.

Top module: `gpio_port8`

## Requirements
- R1: The output latch (address 0) and the direction register (address 1) are 8 bits wide. A bus write in `MODE_RUN` is visible on the read port in the next cycle.
- R2: Asserting `por_n` low clears the output latch, the direction register and both synchronizer stages to 0x00 at once. After that, the pin view (address 2) follows the pin levels.
- R3: On each clock edge where `hw_stby` is high, the output latch and the direction register become 0x00. While the registered state is `MODE_HW_STBY`, `pin_oe` is 0x00.
- R4: On each clock edge where `mrst_n` is low (and `hw_stby` is low), the output latch and the direction register keep their values, and bus writes are ignored.
- R5: On each clock edge where `sw_stby` alone is active, bus writes are ignored, both registers keep their values, and the synchronizer does not update. The pin view therefore stays frozen.
- R6: A read of address 2 returns, for each bit, the output latch bit where the direction bit is 1 and the synchronized pin level where the direction bit is 0.
- R7: A write to address 2 or address 3 changes no state.
- R8: A change on `pin_in` appears in the pin view after exactly two clock edges, not after one.
- R9: Outside `MODE_HW_STBY`, `pin_out` equals the output latch and `pin_oe` equals the direction register.
- R10: When several controls are active at once, hardware standby takes precedence over manual reset, and manual reset takes precedence over software standby. Under manual reset with software standby, the synchronizer keeps running.
- R11: `bus_rdata` is 0x00 when `bus_rd` is low, and it is 0x00 when address 3 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| bus_addr | input | 2 | Register select: 0 output latch, 1 direction, 2 pin view, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Input levels from the pads |
| pin_out | output | 8 | Output values to the pads |
| pin_oe | output | 8 | Output enables to the pads, 1 drives |

## Verification
The per-bit read multiplexing is tried with a split direction mask (low nibble output, high nibble input). A pin pattern that differs from the latch in both halves shows whether each bit takes the correct source. A single pin step is watched edge by edge, which separates a two-stage delay from a one-stage or three-stage delay. The control inputs are raised alone, in pairs and all together, and writes are attempted under each. This tells apart clearing, retention and freezing, and shows the precedence order. A long random phase then mixes all inputs and compares every output against a behavioural model on every clock.

// File: rtl/gpio_port8_pkg.sv
package gpio_port8_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        MODE_RUN        = 2'd0,
        MODE_MANUAL_RST = 2'd1,
        MODE_SW_STBY    = 2'd2,
        MODE_HW_STBY    = 2'd3
    } port_mode_e;

    localparam logic [ADDR_W-1:0] SEL_LATCH = 2'd0;
    localparam logic [ADDR_W-1:0] SEL_DIR   = 2'd1;
    localparam logic [ADDR_W-1:0] SEL_VIEW  = 2'd2;
endpackage

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm
    import gpio_port8_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       mrst_n,
    input  logic       hw_stby,
    input  logic       sw_stby,
    output port_mode_e mode_nxt,
    output port_mode_e mode_q,
    output logic       wr_allow,
    output logic       sync_run,
    output logic       reg_clear,
    output logic       oe_kill
);
    // Next state depends on the inputs only; the priority sets every arc.
    always_comb begin
        if (hw_stby)      mode_nxt = MODE_HW_STBY;
        else if (!mrst_n) mode_nxt = MODE_MANUAL_RST;
        else if (sw_stby) mode_nxt = MODE_SW_STBY;
        else              mode_nxt = MODE_RUN;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_nxt;
    end

    // Controls for the edge being taken come from the state being entered.
    always_comb begin
        wr_allow  = 1'b0;
        sync_run  = 1'b1;
        reg_clear = 1'b0;
        unique case (mode_nxt)
            MODE_RUN:        wr_allow  = 1'b1;
            MODE_MANUAL_RST: ;
            MODE_SW_STBY:    sync_run  = 1'b0;
            MODE_HW_STBY:    reg_clear = 1'b1;
            default:         ;
        endcase
    end

    assign oe_kill = (mode_q == MODE_HW_STBY);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              reg_clear,
    input  logic              wr_allow,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q
);
    logic wr_latch;
    logic wr_dir;

    assign wr_latch = wr_allow && bus_wr && (bus_addr == SEL_LATCH);
    assign wr_dir   = wr_allow && bus_wr && (bus_addr == SEL_DIR);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (reg_clear) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (wr_latch) latch_q <= bus_wdata;
            if (wr_dir)   dir_q   <= bus_wdata;
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         run,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)   chain <= '0;
            else if (run) chain <= {chain[STAGES-2:0], pin_in[b]};
        end
        assign pin_sync[b] = chain[LAST];
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      latch_q,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      bus_rdata
);
    logic [W-1:0] view;

    for (genvar b = 0; b < W; b++) begin : g_view
        assign view[b] = dir_q[b] ? latch_q[b] : pin_sync[b];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                SEL_LATCH: bus_rdata = latch_q;
                SEL_DIR:   bus_rdata = dir_q;
                SEL_VIEW:  bus_rdata = view;
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
    import gpio_port8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe
);
    port_mode_e   mode_nxt;
    port_mode_e   mode_q;
    logic         wr_allow;
    logic         sync_run;
    logic         reg_clear;
    logic         oe_kill;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] pin_sync;

    gpio_mode_fsm u_fsm (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .mode_nxt(mode_nxt), .mode_q(mode_q),
        .wr_allow(wr_allow), .sync_run(sync_run), .reg_clear(reg_clear),
        .oe_kill(oe_kill)
    );

    gpio_port_regs #(.W(W)) u_regs (
        .clk(clk), .por_n(por_n), .reg_clear(reg_clear), .wr_allow(wr_allow),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_pin_sync #(.W(W), .STAGES(2)) u_sync (
        .clk(clk), .por_n(por_n), .run(sync_run), .pin_in(pin_in),
        .pin_sync(pin_sync)
    );

    gpio_read_mux #(.W(W)) u_rmux (
        .bus_rd(bus_rd), .bus_addr(bus_addr), .latch_q(latch_q),
        .dir_q(dir_q), .pin_sync(pin_sync), .bus_rdata(bus_rdata)
    );

    assign pin_out = latch_q;
    assign pin_oe  = oe_kill ? '0 : dir_q;
endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk
    import gpio_port8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              mrst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      latch_q,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      pin_sync,
    input logic [W-1:0]      pin_oe,
    input port_mode_e        mode_q
);
    p_hw_clear_r3: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (latch_q == '0 && dir_q == '0));

    p_hw_oe_off_r3: assert property (@(posedge clk) disable iff (!por_n)
        (mode_q == MODE_HW_STBY) |-> (pin_oe == '0));

    p_mrst_keep_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!mrst_n && !hw_stby) |=> (latch_q == $past(latch_q) && dir_q == $past(dir_q)));

    p_sw_freeze_r5: assert property (@(posedge clk) disable iff (!por_n)
        (sw_stby && mrst_n && !hw_stby) |=>
            (latch_q == $past(latch_q) && pin_sync == $past(pin_sync)));

    p_view_mix_r6: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && bus_addr == SEL_VIEW) |->
            (bus_rdata == ((latch_q & dir_q) | (pin_sync & ~dir_q))));

    p_idle_read_r11: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind gpio_port8 gpio_port8_chk #(.W(W)) u_chk (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .latch_q(latch_q), .dir_q(dir_q),
    .pin_sync(pin_sync), .pin_oe(pin_oe), .mode_q(mode_q)
);

// File: tb/test_gpio_port8.sv
`timescale 1ns/1ps
module test_gpio_port8;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       mrst_n = 1'b1;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    gpio_port8 i_gpio_port8 (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Behavioural reference: 0 run, 1 manual reset, 2 sw standby, 3 hw standby
    byte unsigned m_latch = 0, m_dir = 0;
    byte unsigned m_pipe[2] = '{0, 0};
    int           m_state = 0;

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_latch = 0; m_dir = 0; m_pipe[0] = 0; m_pipe[1] = 0; m_state = 0;
        end else begin
            int st;
            st = hw_stby ? 3 : (!mrst_n ? 1 : (sw_stby ? 2 : 0));
            if (st == 3) begin
                m_latch = 0; m_dir = 0;
            end else if (st == 0 && bus_wr) begin
                if (bus_addr == 2'd0) m_latch = bus_wdata;
                if (bus_addr == 2'd1) m_dir = bus_wdata;
            end
            if (st != 2) begin
                m_pipe[1] = m_pipe[0];
                m_pipe[0] = pin_in;
            end
            m_state = st;
        end
    end

    function automatic byte unsigned exp_rdata();
        if (!bus_rd) return 0;
        case (bus_addr)
            2'd0: return m_latch;
            2'd1: return m_dir;
            2'd2: return (m_latch & m_dir) | (m_pipe[1] & ~m_dir);
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check((m_state == 3) ? "R3" : "R9", "pin_oe", pin_oe,
              (m_state == 3) ? 8'h00 : m_dir);
        check("R9", "pin_out", pin_out, m_latch);
        check(cur_req, "bus_rdata", bus_rdata, exp_rdata());
    endtask

    // Wait for the next falling edge, compare everything, then return for new stimulus
    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        #1;
        check(req, "directed read", bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R2: power-on reset, then the view follows the pins
        pin_in = 8'hA5;
        #12;
        check("R2", "latch in reset", pin_out, 8'h00);
        check("R2", "oe in reset", pin_oe, 8'h00);
        @(negedge clk);
        por_n = 1'b1;
        step(3);
        rd_expect(2'd2, 8'hA5, "R2");
        rd_expect(2'd0, 8'h00, "R2");

        // R1 and R9: writes land on the next edge
        cur_req = "R1";
        wr(2'd0, 8'h3C);
        rd_expect(2'd0, 8'h3C, "R1");
        wr(2'd1, 8'h0F);
        rd_expect(2'd1, 8'h0F, "R1");
        check("R9", "pin_out after write", pin_out, 8'h3C);
        check("R9", "pin_oe after write", pin_oe, 8'h0F);

        // R6: split direction mask
        cur_req = "R6";
        pin_in = 8'h5A;
        step(3);
        rd_expect(2'd2, 8'h5C, "R6");

        // R8: exactly two edges of delay
        cur_req = "R8";
        pin_in = 8'hFF;
        step(1);
        rd_expect(2'd2, 8'h5C, "R8");
        step(1);
        rd_expect(2'd2, 8'hFC, "R8");

        // R7: writes to the view address and the spare address change nothing
        cur_req = "R7";
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hFF);
        step(1);
        rd_expect(2'd0, 8'h3C, "R7");
        rd_expect(2'd1, 8'h0F, "R7");

        // R4: manual reset keeps the registers and blocks writes
        cur_req = "R4";
        mrst_n = 1'b0;
        wr(2'd0, 8'h99);
        step(2);
        mrst_n = 1'b1;
        step(1);
        rd_expect(2'd0, 8'h3C, "R4");

        // R5: software standby freezes the view and blocks writes
        cur_req = "R5";
        sw_stby = 1'b1;
        pin_in = 8'h00;
        wr(2'd1, 8'hF0);
        step(3);
        rd_expect(2'd2, 8'hFC, "R5");
        rd_expect(2'd1, 8'h0F, "R5");
        sw_stby = 1'b0;
        step(2);
        rd_expect(2'd2, 8'h0C, "R5");

        // R10: manual reset beats software standby, so the synchronizer runs
        cur_req = "R10";
        mrst_n = 1'b0; sw_stby = 1'b1;
        pin_in = 8'hF0;
        step(3);
        rd_expect(2'd2, 8'hFC, "R10");
        // R10: hardware standby beats both and clears
        hw_stby = 1'b1;
        step(1);
        rd_expect(2'd0, 8'h00, "R10");
        hw_stby = 1'b0; mrst_n = 1'b1; sw_stby = 1'b0;
        step(1);

        // R3: hardware standby clears and kills the enables
        cur_req = "R3";
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'hFF);
        hw_stby = 1'b1;
        wr(2'd0, 8'h11);
        check("R3", "pin_oe in hw standby", pin_oe, 8'h00);
        rd_expect(2'd1, 8'h00, "R3");
        rd_expect(2'd2, 8'hF0, "R3");
        hw_stby = 1'b0;
        step(1);
        rd_expect(2'd0, 8'h00, "R3");

        // R11: idle and spare-address reads
        cur_req = "R11";
        wr(2'd0, 8'h77);
        bus_addr = 2'd0; bus_rd = 1'b0; #1;
        check("R11", "idle read", bus_rdata, 8'h00);
        rd_expect(2'd3, 8'h00, "R11");

        // Random mix compared against the model every clock
        cur_req = "R6";
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            hw_stby   = (r < 4);
            mrst_n    = !(r >= 4 && r < 10);
            sw_stby   = (r >= 8 && r < 20);
            bus_addr  = 2'($urandom_range(0, 3));
            bus_wr    = ($urandom_range(0, 1) == 1);
            bus_rd    = ($urandom_range(0, 1) == 1);
            bus_wdata = 8'($urandom);
            pin_in    = 8'($urandom);
            step(1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule